// File: doc/BRIEF.md
# SPI Slave Character Receiver with Abort Detection

This block is the receive side of an SPI slave. The master drives the serial clock, data-in and select pins. All three pins are brought into the system clock domain through a synchroniser chain. Bits are taken on the detected serial-clock edge, most significant bit first, into a shift register. A character is 1 to 8 bits long, as set by a length field. When the last bit of a character arrives, the block presents the received character with a one-cycle valid strobe and sets its interrupt flag. Select may stay low across any number of characters.

If select is released before a character is finished, the partial character is dropped and the bit counter restarts. A sticky abort flag and the interrupt flag are then both set. Software works through a small write port. Writing 1 to the interrupt bit clears the interrupt, and writing 1 to the abort bit clears the abort flag. Writing 1 to the force bit raises the interrupt with no transfer, which lets a handler start a transfer. While select is low, the slave also returns a character of its own on the data-out pin, most significant bit first.

Top module: `spi_slv_rx`

## Requirements
- R1: After reset, `irq`, `abort_flag`, `rx_valid` and `miso_pin` are all 0.
- R2: A `char_len` value of 1 to 7 gives a character of that many bits, and 0 gives 8 bits. A character ends on its last sampled edge and gives exactly one `rx_valid` cycle. `rx_data` holds the character right-aligned, with the unused upper bits at 0.
- R3: Bits are taken on the rising serial-clock edge, most significant first. The first bit sampled ends up in `rx_data[N-1]`, where N is the character length.
- R4: With select held low, characters may follow back to back. Each one produces its own `rx_valid` and sets `irq` on the cycle after the strobe.
- R5: If select goes high after at least one bit but before the last bit of a character, `abort_flag` and `irq` are set and no `rx_valid` is given. The next character starts again from its first bit.
- R6: If select goes high with no partial character in progress, `abort_flag` is not set.
- R7: A write with `reg_wdata[0]`=1 clears `irq`. A write with that bit at 0 leaves `irq` unchanged. Once set, `irq` stays set until it is cleared.
- R8: `abort_flag` is sticky. Only a write with `reg_wdata[1]`=1 clears it, and clearing `irq` leaves it set.
- R9: A write with `reg_wdata[2]`=1 sets `irq` on the following cycle.
- R10: While select is low, `miso_pin` presents `tx_data[N-1]` first and then each lower bit in turn, one bit per sampled edge. While select is high, `miso_pin` is 0.
- R11: Serial-clock edges that arrive while select is high are ignored. They give no `rx_valid` and do not shift the next character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_pin | input | 1 | Serial clock from the master |
| mosi_pin | input | 1 | Serial data from the master |
| ss_n_pin | input | 1 | Active-low slave select |
| miso_pin | output | 1 | Serial data to the master |
| char_len | input | 3 | Character length (0 means 8 bits) |
| tx_data | input | 8 | Character returned to the master, right-aligned |
| reg_wr | input | 1 | Write strobe for the control/status bits |
| reg_wdata | input | 3 | Bit 0 clears irq, bit 1 clears abort, bit 2 forces irq |
| rx_data | output | 8 | Last complete character, right-aligned |
| rx_valid | output | 1 | One-cycle strobe when a character completes |
| abort_flag | output | 1 | Sticky early-release error |
| irq | output | 1 | Interrupt request flag |

## Verification
The receiver is first driven with a full 8-bit character whose bit pattern is asymmetric. If the bit order or the alignment were wrong, the result would differ. Three lengths (3, 1 and 7) then follow back to back under one select. This separates the length decode and the counter wrap from per-select resetting. A partial character followed by a fresh one shows the difference between dropping bits and keeping them. Clock pulses sent with select high show whether deselected edges are ignored. The returned data-out bits are compared before every sampling edge.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
   // Bit positions in the write port
   localparam int WB_IRQ   = 0;
   localparam int WB_ABORT = 1;
   localparam int WB_FORCE = 2;
   localparam int WR_W     = 3;

   typedef struct packed {
      logic done;
      logic abort;
   } rx_evt_t;
endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
   parameter int                 WIDTH   = 3,
   parameter int                 STAGES  = 2,
   parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q_out
);
   if (STAGES < 1) begin : g_bad_stages
      $error("spi_rx_sync: STAGES must be at least 1");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= d_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q_out = stg[STAGES-1];
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
   parameter int MAX_BITS       = 8,
   parameter bit SAMPLE_ON_FALL = 1'b0,
   parameter int LEN_W          = $clog2(MAX_BITS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sck_s,
   input  logic                 mosi_s,
   input  logic                 ss_n_s,
   input  logic [LEN_W-1:0]     char_len,
   input  logic [MAX_BITS-1:0]  tx_data,
   output logic                 miso,
   output logic [MAX_BITS-1:0]  rx_data,
   output spi_rx_pkg::rx_evt_t  evt
);
   logic                sck_q;
   logic                take;
   logic [LEN_W-1:0]    bit_cnt;
   logic [LEN_W-1:0]    last_idx;
   logic [LEN_W-1:0]    tx_idx;
   logic [MAX_BITS-1:0] sh;
   logic [MAX_BITS-1:0] sh_nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_q <= 1'b0;
      else        sck_q <= sck_s;
   end

   // The parameter selects which serial-clock edge samples
   if (SAMPLE_ON_FALL) begin : g_fall
      assign take = sck_q & ~sck_s;
   end else begin : g_rise
      assign take = sck_s & ~sck_q;
   end

   // A length field of zero wraps to the full width
   assign last_idx = char_len - LEN_W'(1);
   assign tx_idx   = last_idx - bit_cnt;
   assign miso     = ~ss_n_s & tx_data[tx_idx];

   always_comb begin
      if (bit_cnt == '0) sh_nxt = {{(MAX_BITS-1){1'b0}}, mosi_s};
      else               sh_nxt = {sh[MAX_BITS-2:0], mosi_s};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         sh        <= '0;
         rx_data   <= '0;
         evt.done  <= 1'b0;
         evt.abort <= 1'b0;
      end else begin
         evt.done  <= 1'b0;
         evt.abort <= 1'b0;
         if (ss_n_s) begin
            bit_cnt   <= '0;
            evt.abort <= (bit_cnt != '0);
         end else if (take) begin
            sh <= sh_nxt;
            if (bit_cnt == last_idx) begin
               bit_cnt  <= '0;
               rx_data  <= sh_nxt;
               evt.done <= 1'b1;
            end else begin
               bit_cnt <= bit_cnt + LEN_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/spi_rx_stat.sv
module spi_rx_stat
   import spi_rx_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  rx_evt_t         evt,
   input  logic            wr_en,
   input  logic [WR_W-1:0] wr_data,
   output logic            irq,
   output logic            abort_flag
);
   logic force_irq, clr_irq, clr_abort;

   assign force_irq = wr_en & wr_data[WB_FORCE];
   assign clr_irq   = wr_en & wr_data[WB_IRQ];
   assign clr_abort = wr_en & wr_data[WB_ABORT];

   // A new event wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq        <= 1'b0;
         abort_flag <= 1'b0;
      end else begin
         if (evt.done | evt.abort | force_irq) irq <= 1'b1;
         else if (clr_irq)                     irq <= 1'b0;
         if (evt.abort)                        abort_flag <= 1'b1;
         else if (clr_abort)                   abort_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/spi_slv_rx.sv
module spi_slv_rx
   import spi_rx_pkg::*;
#(
   parameter int MAX_BITS       = 8,
   parameter int SYNC_STAGES    = 2,
   parameter bit SAMPLE_ON_FALL = 1'b0,
   parameter int LEN_W          = $clog2(MAX_BITS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sck_pin,
   input  logic                mosi_pin,
   input  logic                ss_n_pin,
   output logic                miso_pin,
   input  logic [LEN_W-1:0]    char_len,
   input  logic [MAX_BITS-1:0] tx_data,
   input  logic                reg_wr,
   input  logic [WR_W-1:0]     reg_wdata,
   output logic [MAX_BITS-1:0] rx_data,
   output logic                rx_valid,
   output logic                abort_flag,
   output logic                irq
);
   if (MAX_BITS < 2 || (MAX_BITS & (MAX_BITS - 1)) != 0) begin : g_bad_bits
      $error("spi_slv_rx: MAX_BITS must be a power of two of at least 2");
   end
   if (LEN_W != $clog2(MAX_BITS)) begin : g_bad_len
      $error("spi_slv_rx: LEN_W must equal clog2(MAX_BITS)");
   end

   logic    sck_s, mosi_s, ss_n_s;
   rx_evt_t evt;

   spi_rx_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({ss_n_pin, sck_pin, mosi_pin}),
      .q_out ({ss_n_s, sck_s, mosi_s})
   );

   spi_rx_shift #(
      .MAX_BITS       (MAX_BITS),
      .SAMPLE_ON_FALL (SAMPLE_ON_FALL),
      .LEN_W          (LEN_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck_s    (sck_s),
      .mosi_s   (mosi_s),
      .ss_n_s   (ss_n_s),
      .char_len (char_len),
      .tx_data  (tx_data),
      .miso     (miso_pin),
      .rx_data  (rx_data),
      .evt      (evt)
   );

   spi_rx_stat u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (evt),
      .wr_en      (reg_wr),
      .wr_data    (reg_wdata),
      .irq        (irq),
      .abort_flag (abort_flag)
   );

   assign rx_valid = evt.done;
endmodule

// File: rtl/spi_slv_rx_chk.sv
module spi_slv_rx_chk
   import spi_rx_pkg::*;
(
   input logic            clk,
   input logic            rst_n,
   input logic            ss_n_s,
   input logic            rx_valid,
   input logic            irq,
   input logic            abort_flag,
   input logic            reg_wr,
   input logic [WR_W-1:0] reg_wdata
);
   AST_VALID_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(!ss_n_s));                                            // R11
   AST_VALID_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> irq);                                                       // R4
   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);                                                 // R2
   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(reg_wr && reg_wdata[WB_IRQ])) |=> irq);                        // R7
   AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_flag && !(reg_wr && reg_wdata[WB_ABORT])) |=> abort_flag);        // R8
   AST_FORCE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_wdata[WB_FORCE]) |=> irq);                                // R9
endmodule

bind spi_slv_rx spi_slv_rx_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ss_n_s     (ss_n_s),
   .rx_valid   (rx_valid),
   .irq        (irq),
   .abort_flag (abort_flag),
   .reg_wr     (reg_wr),
   .reg_wdata  (reg_wdata)
);

// File: tb/spi_slv_rx_bench.sv
`timescale 1ns/1ps
module spi_slv_rx_bench;
   localparam int H = 4;   // system clocks per serial-clock half period

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck_pin = 1'b0, mosi_pin = 1'b0, ss_n_pin = 1'b1;
   logic       miso_pin;
   logic [2:0] char_len = 3'd0;
   logic [7:0] tx_data = 8'h00;
   logic       reg_wr = 1'b0;
   logic [2:0] reg_wdata = 3'd0;
   logic [7:0] rx_data;
   logic       rx_valid, abort_flag, irq;

   int checks = 0;
   int errors = 0;
   int n_valid = 0;
   int n_pushed = 0;
   logic [7:0] exp_q [$];

   always #10 clk = ~clk;

   spi_slv_rx u_spi_slv_rx (
      .clk(clk), .rst_n(rst_n), .sck_pin(sck_pin), .mosi_pin(mosi_pin),
      .ss_n_pin(ss_n_pin), .miso_pin(miso_pin), .char_len(char_len),
      .tx_data(tx_data), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .rx_data(rx_data), .rx_valid(rx_valid), .abort_flag(abort_flag), .irq(irq)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Monitor: pop the scoreboard on every completed character
   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         n_valid++;
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R2 R3 R5 R11 actual=%0h expected=none (unexpected character)", rx_data);
         end else begin
            check("R2 R3 rx_data", {24'd0, rx_data}, {24'd0, exp_q.pop_front()});
         end
      end
   end

   task automatic wr(logic [2:0] v);
      @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
      @(negedge clk); reg_wr = 1'b0; reg_wdata = 3'd0;
      repeat (2) @(negedge clk);
   endtask

   task automatic sel();
      @(negedge clk); ss_n_pin = 1'b0;
      repeat (H) @(negedge clk);
   endtask

   task automatic desel();
      repeat (H) @(negedge clk);
      ss_n_pin = 1'b1;
      repeat (10) @(negedge clk);
   endtask

   // Driver: n-bit character, only k bits are clocked; pushed when complete
   task automatic send_char(int n, logic [7:0] d, logic [7:0] tx, int k);
      logic [7:0] mask;
      mask = 8'((16'd1 << n) - 16'd1);
      char_len = 3'(n);
      tx_data  = tx;
      if (k == n) begin
         exp_q.push_back(d & mask);
         n_pushed++;
      end
      for (int i = n - 1; i >= n - k; i--) begin
         mosi_pin = d[i];
         repeat (H) @(negedge clk);
         check("R10 miso bit", {31'd0, miso_pin}, {31'd0, tx[i]});
         sck_pin = 1'b1;
         repeat (H) @(negedge clk);
         sck_pin = 1'b0;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 irq", {31'd0, irq}, 0);
      check("R1 abort", {31'd0, abort_flag}, 0);
      check("R1 rx_valid", {31'd0, rx_valid}, 0);
      check("R1 miso", {31'd0, miso_pin}, 0);

      // 8-bit character (length field 0), asymmetric pattern
      sel();
      send_char(8, 8'hA5, 8'h3C, 8);
      repeat (10) @(negedge clk);
      check("R4 irq after char", {31'd0, irq}, 1);
      desel();
      check("R6 no abort on clean release", {31'd0, abort_flag}, 0);
      check("R10 miso idle", {31'd0, miso_pin}, 0);

      wr(3'b000);
      check("R7 write 0 keeps irq", {31'd0, irq}, 1);
      wr(3'b001);
      check("R7 clear irq", {31'd0, irq}, 0);

      // Back-to-back characters of 3, 1 and 7 bits under one select
      sel();
      send_char(3, 8'h05, 8'h06, 3);
      send_char(1, 8'h01, 8'h00, 1);
      send_char(7, 8'h55, 8'h2A, 7);
      repeat (10) @(negedge clk);
      check("R4 irq after stream", {31'd0, irq}, 1);
      desel();
      check("R4 three characters", n_valid, 4);
      wr(3'b001);

      // Early release after 3 of 8 bits
      sel();
      send_char(8, 8'hFF, 8'hF0, 3);
      desel();
      check("R5 abort set", {31'd0, abort_flag}, 1);
      check("R5 irq set", {31'd0, irq}, 1);
      check("R5 no character", n_valid, 4);
      wr(3'b001);
      check("R7 irq cleared", {31'd0, irq}, 0);
      check("R8 abort survives irq clear", {31'd0, abort_flag}, 1);
      wr(3'b010);
      check("R8 abort cleared", {31'd0, abort_flag}, 0);

      // Fresh character after the abort starts at bit 0
      sel();
      send_char(8, 8'h81, 8'hC3, 8);
      desel();
      check("R5 restart", n_valid, 5);
      check("R6 abort stays clear", {31'd0, abort_flag}, 0);
      wr(3'b001);

      // Clock pulses while deselected are ignored
      mosi_pin = 1'b1;
      for (int p = 0; p < 5; p++) begin
         repeat (H) @(negedge clk); sck_pin = 1'b1;
         repeat (H) @(negedge clk); sck_pin = 1'b0;
      end
      repeat (10) @(negedge clk);
      check("R11 no character while deselected", n_valid, 5);
      check("R11 no irq while deselected", {31'd0, irq}, 0);
      sel();
      send_char(4, 8'h09, 8'h06, 4);
      desel();
      check("R11 next character intact", n_valid, 6);
      wr(3'b001);

      wr(3'b100);
      check("R9 forced irq", {31'd0, irq}, 1);

      check("R2 scoreboard drained", exp_q.size(), 0);
      check("R2 one strobe per character", n_valid, n_pushed);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule